// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a two-wire serial bus slave that holds sixteen 8-bit configuration registers for a mixed-signal front end. After the device address, the bus master sends a control byte. The low nibble of that byte selects a register index. The upper bits carry three flags: an index-advance enable, a test enable and a keep-calibration flag. Any number of data bytes may follow the control byte. Each data byte is acknowledged and stored, and the index moves to the next register only when the advance flag is set.

A read transaction returns one status byte that reflects two live inputs: mute-in-progress and stereo pilot detected. Storing a byte into register 0 (the source selector) raises a single-cycle `cal_start_o` pulse, which asks the analog side to cancel its offset. When the keep-calibration flag is set, no pulse is raised, so the master can refresh register 0 without an audible mute. The test output is high only when the last control byte had its test flag set and bit 0 of register 15 is 1.

Both bus lines pass through a two-flop synchronizer and a stability filter before START and STOP are detected. The filter lets the slave follow a 500 kbit/s bus with a system clock of a few tens of MHz.

Top module: `ctl_reg_slave`

## Requirements
- R1: The slave answers only device address 7'b1000110, with the R/W bit appended as bit 0 (1 = read). For any other address it does not pull SDA low and does not change any register.
- R2: In the control byte, bit 6 is keep-calibration, bit 5 is test, bit 4 is index-advance and bits 3:0 are the register index. Every data byte that follows is acknowledged with SDA low and stored in the indexed register.
- R3: When index-advance is 1, the index increments after each stored byte. When it is 0, every byte of the transaction lands in the same register.
- R4: An advancing index wraps from 15 to 0.
- R5: Storing a byte into register 0 raises `cal_start_o` for exactly one clock cycle, unless the control byte of that transaction had bit 6 set. Stores to other registers never raise it.
- R6: Each read byte carries `mute_active_i` in bit 3 and `stereo_det_i` in bit 4, with all other bits 0. Further bytes follow for as long as the master acknowledges.
- R7: `test_en_o` is 1 exactly when the most recent control byte had bit 5 set and bit 0 of register 15 is 1.
- R8: After reset, register 15 holds 8'hFE, all other registers hold 0, and `sda_oe_o`, `cal_start_o` and `test_en_o` are 0.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_LEN clock cycles is ignored.
- R10: Register k appears on `regs_o[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| mute_active_i | input | 1 | Status: mute ramp in progress |
| stereo_det_i | input | 1 | Status: stereo pilot detected |
| regs_o | output | 128 | All sixteen registers, register k in bits 8k+7:8k |
| cal_start_o | output | 1 | One-cycle request to start offset calibration |
| test_en_o | output | 1 | Test mode enable |

## Verification
Two events can fall in the same cycle: the acknowledge of a data byte and the index-advance step that wraps from 15 to 0. A single burst that starts at index 15 with advance enabled exercises this case. The first byte must land in register 15 and the second in register 0. The store into register 0 must produce exactly one calibration pulse, and that pulse disappears when the same burst is repeated with the keep-calibration flag set.

// File: rtl/ctl_reg_pkg.sv
// Package: shared constants and types for the serial control register slave.
// Assumes the control-byte layout is fixed: index in bits 3:0, flags above.
package ctl_reg_pkg;
    localparam int IDX_W      = 4;
    localparam int NREG       = 1 << IDX_W;
    localparam int CB_ADV     = 4;
    localparam int CB_TEST    = 5;
    localparam int CB_KEEP    = 6;
    localparam int ST_MUTE_B  = 3;
    localparam int ST_STEREO_B = 4;
    localparam logic [7:0] TEST_REG_RST = 8'hFE;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_CTRL,
        BS_WRITE,
        BS_READ
    } bus_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
// Module: two-flop synchronizer followed by a stability filter.
// The output takes a new level only after the synchronized input has
// differed from it for FILT_LEN consecutive clocks. Idle level is 1.
module i2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] run_cnt;

    // Bring the pad level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= line_i;
            s2 <= s1;
        end
    end

    // Accept a new level only once it has persisted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o  <= 1'b1;
            run_cnt <= '0;
        end else if (s2 == line_o) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_LEN - 1)) begin
            line_o  <= s2;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_FILT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(s2, 2) == line_o)); // R9
endmodule

// File: rtl/i2c_bus_fsm.sv
// Module: bus protocol engine. Detects START/STOP on filtered lines,
// matches the device address, decodes the control byte, issues write
// strobes and shifts out the status byte. Bits are sampled on SCL rise
// and SDA is changed only after SCL fall.
module i2c_bus_fsm
    import ctl_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1000110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl,
    input  logic             sda,
    input  logic             stat_mute,
    input  logic             stat_stereo,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             wr_keep,
    output logic             ctl_test
);
    bus_state_t       state;
    logic [3:0]       cnt;
    logic [7:0]       shreg;
    logic [7:0]       txreg;
    logic [IDX_W-1:0] idx;
    logic             rw, adv, keep, mack;
    logic             scl_q, sda_q;
    logic             scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]       stat_byte;

    // Remember the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_q;
    assign scl_fall  = ~scl & scl_q;
    assign start_det = scl & scl_q & sda_q & ~sda;
    assign stop_det  = scl & scl_q & ~sda_q & sda;

    // Assemble the status byte from the live inputs.
    always_comb begin
        stat_byte              = 8'h00;
        stat_byte[ST_MUTE_B]   = stat_mute;
        stat_byte[ST_STEREO_B] = stat_stereo;
    end

    // Protocol sequencing: byte reception, acknowledge and read shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= BS_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            txreg    <= '0;
            idx      <= '0;
            rw       <= 1'b0;
            adv      <= 1'b0;
            keep     <= 1'b0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            wr_keep  <= 1'b0;
            ctl_test <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= BS_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= BS_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (state != BS_IDLE) begin
                if (scl_rise) begin
                    if (cnt < 4'd8) begin
                        shreg <= {shreg[6:0], sda};
                        cnt   <= cnt + 1'b1;
                    end else if (cnt == 4'd9 && state == BS_READ) begin
                        mack <= ~sda;
                    end
                end else if (scl_fall) begin
                    if (state == BS_READ) begin
                        if (cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            cnt    <= 4'd9;
                        end else if (cnt == 4'd9) begin
                            cnt <= '0;
                            if (mack) begin
                                txreg  <= stat_byte;
                                sda_oe <= ~stat_byte[7];
                            end else begin
                                state  <= BS_IDLE;
                                sda_oe <= 1'b0;
                            end
                        end else if (cnt != 4'd0) begin
                            sda_oe <= ~txreg[6];
                            txreg  <= {txreg[6:0], 1'b0};
                        end
                    end else if (cnt == 4'd8) begin
                        cnt <= 4'd9;
                        case (state)
                            BS_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                end else begin
                                    state <= BS_IDLE;
                                    cnt   <= '0;
                                end
                            end
                            BS_CTRL: begin
                                sda_oe   <= 1'b1;
                                idx      <= shreg[IDX_W-1:0];
                                adv      <= shreg[CB_ADV];
                                ctl_test <= shreg[CB_TEST];
                                keep     <= shreg[CB_KEEP];
                            end
                            default: begin
                                sda_oe  <= 1'b1;
                                wr_en   <= 1'b1;
                                wr_idx  <= idx;
                                wr_data <= shreg;
                                wr_keep <= keep;
                                if (adv) idx <= idx + 1'b1;
                            end
                        endcase
                    end else if (cnt == 4'd9) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        if (state == BS_ADDR) begin
                            if (rw) begin
                                state  <= BS_READ;
                                txreg  <= stat_byte;
                                sda_oe <= ~stat_byte[7];
                            end else begin
                                state <= BS_CTRL;
                            end
                        end else if (state == BS_CTRL) begin
                            state <= BS_WRITE;
                        end
                    end
                end
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BS_IDLE) |-> !sda_oe); // R1

    AST_STORE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe); // R2

    AST_INDEX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BS_WRITE && scl_fall && cnt == 4'd8 && adv &&
         idx == IDX_W'(NREG - 1) && !start_det && !stop_det)
        |=> (idx == '0)); // R4
endmodule

// File: rtl/ctl_reg_bank.sv
// Module: the sixteen configuration registers, the calibration request
// and the test-mode qualification. Assumes at most one store per cycle.
module ctl_reg_bank
    import ctl_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              wr_keep,
    input  logic              ctl_test,
    output logic [NREG*8-1:0] regs_o,
    output logic              cal_start_o,
    output logic              test_en_o
);
    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] RST_VAL = (g == NREG - 1) ? TEST_REG_RST : 8'h00;
        // Hold one register; load it when its index is stored.
        always_ff @(posedge clk) begin
            if (!rst_n) regs[g] <= RST_VAL;
            else if (wr_en && wr_idx == IDX_W'(g)) regs[g] <= wr_data;
        end
        assign regs_o[g*8 +: 8] = regs[g];
    end

    // Request offset calibration on a store to the source selector.
    always_ff @(posedge clk) begin
        if (!rst_n) cal_start_o <= 1'b0;
        else        cal_start_o <= wr_en && (wr_idx == '0) && !wr_keep;
    end

    assign test_en_o = ctl_test & regs[NREG-1][0];

    AST_CAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start_o |=> !cal_start_o); // R5
endmodule

// File: rtl/ctl_reg_slave.sv
// Module: top of the serial control register slave. Filters the bus
// lines, runs the protocol engine and holds the register bank.
// Assumes the clock is at least ~20x the SCL bit rate.
module ctl_reg_slave
    import ctl_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1000110,
    parameter int         FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              mute_active_i,
    input  logic              stereo_det_i,
    output logic [NREG*8-1:0] regs_o,
    output logic              cal_start_o,
    output logic              test_en_o
);
    logic             scl_f, sda_f;
    logic             wr_en, wr_keep, ctl_test;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));

    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

    i2c_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .stat_mute(mute_active_i), .stat_stereo(stereo_det_i),
        .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_keep(wr_keep), .ctl_test(ctl_test));

    ctl_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_keep(wr_keep), .ctl_test(ctl_test),
        .regs_o(regs_o), .cal_start_o(cal_start_o), .test_en_o(test_en_o));
endmodule

// File: tb/ctl_reg_slave_test.sv
// Bench: drives the bus as a master, keeps an arithmetic model of the
// registers and checks acknowledges, stored values, pulses and reads.
module ctl_reg_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 20;
    localparam logic [6:0] ADDR = 7'b1000110;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         m_scl = 1'b1;
    logic         m_sda = 1'b1;
    logic         mute_in = 1'b0;
    logic         stereo_in = 1'b0;
    logic         sda_oe;
    logic [127:0] regs;
    logic         cal_start;
    logic         test_en;
    logic         sda_line;

    int errors = 0;
    int checks = 0;
    int cal_cnt = 0;
    int cal_long = 0;
    logic cal_prev = 1'b0;
    logic [7:0] exp_r [16];
    logic [7:0] wbuf [20];
    logic done = 1'b0;

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .mute_active_i(mute_in), .stereo_det_i(stereo_in),
        .regs_o(regs), .cal_start_o(cal_start), .test_en_o(test_en));

    // Count calibration pulses and any pulse longer than one cycle.
    always @(posedge clk) begin
        if (cal_start && !cal_prev) cal_cnt++;
        if (cal_start && cal_prev) cal_long++;
        cal_prev <= cal_start;
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        logic [127:0] e;
        for (int k = 0; k < 16; k++) e[k*8 +: 8] = exp_r[k];
        check(req, regs, e);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wait_clk(5);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b0; wait_clk(5);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b1; wait_clk(HALF);
    endtask

    // One bit slot; returns the line level sampled mid-high.
    task automatic bit_slot(input logic b, input logic glitch, output logic smp);
        m_scl = 1'b0; wait_clk(5);
        m_sda = b;
        if (glitch) begin
            wait_clk(4); m_scl = 1'b1; wait_clk(1); m_scl = 1'b0; wait_clk(10);
        end else begin
            wait_clk(HALF - 5);
        end
        m_scl = 1'b1; wait_clk(HALF/2);
        smp = sda_line;
        wait_clk(HALF/2);
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input int glitch_bit, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_slot(d[i], (7 - i) == glitch_bit, s);
        bit_slot(1'b1, 1'b0, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_slot(1'b1, 1'b0, s);
            d[i] = s;
        end
        bit_slot(~give_ack, 1'b0, s);
    endtask

    // Burst write of n bytes from wbuf; model updates exp_r and cal count.
    task automatic write_burst(input logic [7:0] ctl, input int n, output int exp_cal, output int nack);
        logic a;
        int ix;
        nack = 0; exp_cal = 0;
        ix = int'(ctl[3:0]);
        bus_start;
        send_byte({ADDR, 1'b0}, -1, a); if (!a) nack++;
        send_byte(ctl, -1, a); if (!a) nack++;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], -1, a); if (!a) nack++;
            exp_r[ix] = wbuf[k];
            if (ix == 0 && !ctl[6]) exp_cal++;
            if (ctl[4]) ix = (ix + 1) % 16;
        end
        bus_stop;
        wait_clk(10);
    endtask

    initial begin
        logic a;
        logic [7:0] rd;
        int ec, nk, c0;
        for (int k = 0; k < 16; k++) exp_r[k] = (k == 15) ? 8'hFE : 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R8: reset state
        check_regs("R8 reset registers");
        check("R8 outputs after reset", {125'd0, sda_oe, cal_start, test_en}, 128'd0);

        // R2/R10: one single-byte write per register index, no advance
        for (int k = 0; k < 16; k++) begin
            wbuf[0] = 8'((k * 37 + 11) ^ 8'h5A);
            c0 = cal_cnt;
            write_burst(8'(k), 1, ec, nk);
            check("R2 data byte acknowledged", 128'(nk), 128'd0);
            check_regs("R10 register placement after single write");
            check("R5 calibration pulses per index", 128'(cal_cnt - c0), 128'(ec));
        end

        // R3: advancing burst over 1..6
        for (int k = 0; k < 6; k++) wbuf[k] = 8'(8'hA0 + k * 3);
        write_burst(8'h11, 6, ec, nk);
        check_regs("R3 advancing burst");

        // R3: no advance, three bytes land in register 7
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h3C;
        write_burst(8'h07, 3, ec, nk);
        check_regs("R3 fixed index burst");

        // R4/R5: wrap 15 -> 0 with calibration pulse
        c0 = cal_cnt;
        wbuf[0] = 8'h00; wbuf[1] = 8'h9E;
        write_burst(8'h1F, 2, ec, nk);
        check_regs("R4 wrap from 15 to 0");
        check("R5 pulse on wrap store", 128'(cal_cnt - c0), 128'd1);

        // R5: same burst with keep-calibration set, no pulse
        c0 = cal_cnt;
        wbuf[0] = 8'h00; wbuf[1] = 8'h4B;
        write_burst(8'h5F, 2, ec, nk);
        check_regs("R5 keep flag still stores");
        check("R5 keep flag suppresses pulse", 128'(cal_cnt - c0), 128'd0);

        // R1: foreign addresses get no acknowledge and change nothing
        for (int k = 0; k < 4; k++) begin
            bus_start;
            send_byte({ADDR ^ 7'(1 << k), 1'b0}, -1, a);
            check("R1 foreign address not acknowledged", 128'(a), 128'd0);
            send_byte(8'h00, -1, a);
            send_byte(8'hFF, -1, a);
            bus_stop;
            wait_clk(10);
        end
        check_regs("R1 registers untouched by foreign writes");

        // R6: read sweep over status inputs, two bytes each
        for (int k = 0; k < 4; k++) begin
            mute_in = k[0]; stereo_in = k[1];
            bus_start;
            send_byte({ADDR, 1'b1}, -1, a);
            check("R1 read address acknowledged", 128'(a), 128'd1);
            recv_byte(1'b1, rd);
            check("R6 first status byte", 128'(rd), 128'(8'(k * 8)));
            recv_byte(1'b0, rd);
            check("R6 second status byte", 128'(rd), 128'(8'(k * 8)));
            bus_stop;
            wait_clk(10);
        end
        mute_in = 1'b0; stereo_in = 1'b0;

        // R7: test enable needs control bit 5 and register 15 bit 0
        for (int k = 0; k < 4; k++) begin
            wbuf[0] = k[0] ? 8'hFF : 8'hFE;
            write_burst(k[1] ? 8'h2F : 8'h0F, 1, ec, nk);
            check("R7 test enable combination", 128'(test_en), 128'(k == 3));
        end

        // R9: short SCL pulse inside a data bit is ignored
        bus_start;
        send_byte({ADDR, 1'b0}, -1, a);
        send_byte(8'h03, -1, a);
        send_byte(8'hC5, 3, a);
        bus_stop;
        wait_clk(10);
        exp_r[3] = 8'hC5;
        check_regs("R9 glitch on SCL ignored");
        check("R9 byte acknowledged despite glitch", 128'(a), 128'd1);

        check("R5 calibration pulse width", 128'(cal_long), 128'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule